// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is one DMA channel. It walks a chain of 8-byte descriptors kept in system memory and moves 32-bit words between a streaming peripheral port and system memory. The build parameter `IS_RX` fixes the direction. When `IS_RX` is 1 the channel takes words from the inbound stream and writes them to memory. When it is 0 the channel reads words from memory and presents them on the outbound stream. Software writes the address of the first descriptor. A receive channel then starts when bit 0 of the control register is written with 1. A transmit channel starts on the write of the low list-address register itself.

Every descriptor is fetched as two little-endian words from consecutive addresses. The first word holds the flags in bits 7:0 and the byte length in bits 31:16. Among the flags, bit 0 marks the entry valid, bit 1 marks it as the final entry and bit 5 marks it as a data-moving entry. Bits 15:8 are reserved. The second word is the buffer address. Entries lie 8 bytes apart.

Completion and descriptor errors raise sticky status bits, which are cleared by writing 1 to them. Each status bit drives the interrupt only while its enable bit is set. Writing 0 to the control register aborts a running channel. A receive channel also pulses `row_end` each time the number of bytes written to memory reaches a programmable row length.

The sequencer has twelve states:
- IDLE waits for a start.
- FETCH_LO issues the read of descriptor word 0, and WAIT_LO takes its response.
- FETCH_HI issues the read of word 1 at the descriptor address plus 4, and WAIT_HI takes its response.
- DECODE goes to IDLE on an invalid entry or an unaligned length. It goes to ADVANCE on an empty entry. Otherwise it goes to PULL (receive) or to MEM_RD (transmit).
- On the transmit path, MEM_RD issues a buffer read, RD_WAIT takes the data and PUSH offers it on the stream. After the handshake, PUSH returns to MEM_RD, or goes to ADVANCE after the final word.
- On the receive path, PULL accepts a stream word and MEM_WR writes it. After the handshake, MEM_WR returns to PULL, or goes to ADVANCE after the final word.
- ADVANCE goes to IDLE when the entry is the last one. Otherwise it steps the descriptor address by 8 and goes to FETCH_LO.
- An abort moves any state to IDLE.

Register map (word index on `reg_addr`):

| Index | Register | Contents |
|-------|----------|----------|
| 0 | control | reads back busy in bit 0 |
| 1 | list address low | first descriptor address |
| 2 | list address high | stored and read back only |
| 3 | row bytes | row length in bytes |
| 4 | status | bit 0 done, bit 1 error, bit 2 busy (read only) |
| 5 | interrupt enable | bit 0 done, bit 1 error |

Top module: `desc_chain_dma`

## Requirements
- R1: After reset, the status register (index 4) and the control register (index 0) read 0, and `irq` is 0.
- R2: The channel fetches descriptor word 0 from the list address and word 1 from the list address plus 4, with the low two address bits forced to 0. It takes flags from bits 7:0 of word 0, the byte length from bits 31:16 of word 0, and the buffer address from word 1. Data words go to or from the buffer address, which increases by 4 per word.
- R3: A receive channel starts only on a write of 1 to bit 0 of control, and a write to the low list register leaves it idle. A transmit channel starts on a write to the low list register (index 1), and a write of 1 to control leaves it idle. While the channel runs, control bit 0 reads 1.
- R4: A descriptor whose valid flag (bit 0) is clear stops the channel. The channel sets status bit 1, leaves status bit 0 clear and moves no data.
- R5: A descriptor whose length is not a multiple of 4 stops the channel and sets status bit 1, and the channel moves no data.
- R6: A descriptor with length 0, or with the transfer flag (bit 5) clear, moves no data. The channel then goes on to the next entry, or completes if that entry is last.
- R7: After an entry without the last flag (bit 1), the next descriptor is fetched 8 bytes further on. After the entry with the last flag completes, status bit 0 is set and the channel goes idle.
- R8: Writing 1 to a status bit clears it, and writing 0 to a status bit leaves it unchanged. `irq` is high exactly when some status bit and its enable bit (index 5) are both set.
- R9: Writing 0 to control while the channel runs returns it to idle by the next cycle and sets neither status bit.
- R10: On a receive channel with a nonzero row length, `row_end` pulses once for every row-length bytes written to memory.
- R11: A transmit channel presents the buffer words on the outbound stream in address order, and holds each word until the stream accepts it.
- R12: The high list register reads back the value written to it and has no effect on fetch addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| reg_wr_en | input | 1 | register write strobe |
| reg_addr | input | 3 | register word index |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | read data for the register at `reg_addr` |
| mem_req_valid | output | 1 | memory request valid |
| mem_req_ready | input | 1 | memory request accepted |
| mem_req_write | output | 1 | 1 for a write request, 0 for a read request |
| mem_req_addr | output | 32 | word-aligned byte address |
| mem_req_wdata | output | 32 | write data |
| mem_rsp_valid | input | 1 | read response valid |
| mem_rsp_rdata | input | 32 | read response data |
| st_in_valid | input | 1 | inbound stream word valid |
| st_in_ready | output | 1 | inbound stream word accepted |
| st_in_data | input | 32 | inbound stream word |
| st_out_valid | output | 1 | outbound stream word valid |
| st_out_ready | input | 1 | outbound stream word accepted |
| st_out_data | output | 32 | outbound stream word |
| row_end | output | 1 | one-cycle pulse at the end of a receive row |
| irq | output | 1 | interrupt request |

## Verification
The bench builds two copies of the block, one with `IS_RX` = 1 and one with `IS_RX` = 0, each attached to its own memory model. The receive copy sees a memory that accepts every request at once. This lets a table of single-descriptor cases cover the valid and invalid flags, unaligned and zero lengths, and the transfer flag, as well as chaining, row pulses and abort. The transmit copy sees a memory that stalls every other request and an outbound stream that stalls, so held requests and held stream words are exercised as well.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = 4;
    localparam int DESC_BYTES = 8;
    localparam int LEN_W      = 16;
    localparam int LEN_LSB    = 16;
    localparam int FLAG_VALID = 0;
    localparam int FLAG_LAST  = 1;
    localparam int FLAG_XFER  = 5;
    localparam int REG_AW     = 3;

    localparam logic [REG_AW-1:0] REG_CTRL    = 3'd0;
    localparam logic [REG_AW-1:0] REG_LIST_LO = 3'd1;
    localparam logic [REG_AW-1:0] REG_LIST_HI = 3'd2;
    localparam logic [REG_AW-1:0] REG_ROW     = 3'd3;
    localparam logic [REG_AW-1:0] REG_STATUS  = 3'd4;
    localparam logic [REG_AW-1:0] REG_IRQEN   = 3'd5;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH_LO,
        S_WAIT_LO,
        S_FETCH_HI,
        S_WAIT_HI,
        S_DECODE,
        S_MEM_RD,
        S_RD_WAIT,
        S_PUSH,
        S_PULL,
        S_MEM_WR,
        S_ADVANCE
    } dmac_state_e;
endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
#(
    parameter bit IS_RX  = 1'b1,
    parameter int ADDR_W = 32,
    parameter int ROW_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              busy,
    input  logic              done_set,
    input  logic              err_set,
    output logic [WORD_W-1:0] rdata,
    output logic [ADDR_W-1:0] start_base,
    output logic [ROW_W-1:0]  row_bytes,
    output logic              start,
    output logic              abort,
    output logic              irq
);
    logic [WORD_W-1:0] list_lo_q;
    logic [WORD_W-1:0] list_hi_q;
    logic [ROW_W-1:0]  row_q;
    logic [1:0]        status_q;
    logic [1:0]        irqen_q;
    logic              wr_ctrl;
    logic              wr_lo;

    assign wr_ctrl = wr_en && (addr == REG_CTRL);
    assign wr_lo   = wr_en && (addr == REG_LIST_LO);

    generate
        if (IS_RX) begin : g_rx_start
            assign start      = wr_ctrl && wdata[0] && !busy;
            assign start_base = list_lo_q[ADDR_W-1:0];
        end else begin : g_tx_start
            assign start      = wr_lo && !busy;
            assign start_base = wdata[ADDR_W-1:0];
        end
    endgenerate

    assign abort     = wr_ctrl && !wdata[0] && busy;
    assign row_bytes = row_q;
    assign irq       = |(status_q & irqen_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            list_lo_q <= '0;
            list_hi_q <= '0;
            row_q     <= '0;
            status_q  <= '0;
            irqen_q   <= '0;
        end else begin
            if (wr_lo)                                list_lo_q <= wdata;
            if (wr_en && (addr == REG_LIST_HI))       list_hi_q <= wdata;
            if (wr_en && (addr == REG_ROW))           row_q     <= wdata[ROW_W-1:0];
            if (wr_en && (addr == REG_IRQEN))         irqen_q   <= wdata[1:0];
            status_q <= (status_q & ~((wr_en && (addr == REG_STATUS)) ? wdata[1:0] : 2'b00))
                      | {err_set, done_set};
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            REG_CTRL:    rdata = {{(WORD_W-1){1'b0}}, busy};
            REG_LIST_LO: rdata = list_lo_q;
            REG_LIST_HI: rdata = list_hi_q;
            REG_ROW:     rdata = {{(WORD_W-ROW_W){1'b0}}, row_q};
            REG_STATUS:  rdata = {{(WORD_W-3){1'b0}}, busy, status_q};
            REG_IRQEN:   rdata = {{(WORD_W-2){1'b0}}, irqen_q};
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
    import dmac_pkg::*;
#(
    parameter bit IS_RX  = 1'b1,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [ADDR_W-1:0] start_base,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [WORD_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_rdata,
    input  logic              st_in_valid,
    output logic              st_in_ready,
    input  logic [WORD_W-1:0] st_in_data,
    output logic              st_out_valid,
    input  logic              st_out_ready,
    output logic [WORD_W-1:0] st_out_data,
    output logic              busy,
    output logic              done_pulse,
    output logic              err_pulse,
    output logic              wr_beat
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(WORD_BYTES - 1);

    dmac_state_e       state_q, state_d;
    logic [ADDR_W-1:0] desc_ptr;
    logic [ADDR_W-1:0] buf_addr;
    logic [LEN_W-1:0]  remain;
    logic [WORD_W-1:0] data_q;
    logic              f_valid, f_last, f_xfer;
    logic              desc_bad, desc_empty, last_beat, beat_done;

    assign desc_bad   = !f_valid || (remain[1:0] != 2'b00);
    assign desc_empty = !f_xfer || (remain == '0);
    assign last_beat  = (remain == LEN_W'(WORD_BYTES));
    assign beat_done  = ((state_q == S_PUSH) && st_out_ready)
                     || ((state_q == S_MEM_WR) && mem_req_ready);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (start)         state_d = S_FETCH_LO;
            S_FETCH_LO: if (mem_req_ready) state_d = S_WAIT_LO;
            S_WAIT_LO:  if (mem_rsp_valid) state_d = S_FETCH_HI;
            S_FETCH_HI: if (mem_req_ready) state_d = S_WAIT_HI;
            S_WAIT_HI:  if (mem_rsp_valid) state_d = S_DECODE;
            S_DECODE: begin
                if (desc_bad)        state_d = S_IDLE;
                else if (desc_empty) state_d = S_ADVANCE;
                else if (IS_RX)      state_d = S_PULL;
                else                 state_d = S_MEM_RD;
            end
            S_MEM_RD:   if (mem_req_ready) state_d = S_RD_WAIT;
            S_RD_WAIT:  if (mem_rsp_valid) state_d = S_PUSH;
            S_PUSH:     if (st_out_ready)  state_d = last_beat ? S_ADVANCE : S_MEM_RD;
            S_PULL:     if (st_in_valid)   state_d = S_MEM_WR;
            S_MEM_WR:   if (mem_req_ready) state_d = last_beat ? S_ADVANCE : S_PULL;
            S_ADVANCE:  state_d = f_last ? S_IDLE : S_FETCH_LO;
            default:    state_d = S_IDLE;
        endcase
        if (abort) state_d = S_IDLE;
    end

    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = buf_addr;
        st_in_ready   = 1'b0;
        st_out_valid  = 1'b0;
        done_pulse    = 1'b0;
        err_pulse     = 1'b0;
        unique case (state_q)
            S_FETCH_LO: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = desc_ptr;
            end
            S_FETCH_HI: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = desc_ptr + ADDR_W'(WORD_BYTES);
            end
            S_DECODE:  err_pulse     = desc_bad && !abort;
            S_MEM_RD:  mem_req_valid = 1'b1;
            S_PUSH:    st_out_valid  = 1'b1;
            S_PULL:    st_in_ready   = 1'b1;
            S_MEM_WR: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
            end
            S_ADVANCE: done_pulse = f_last && !abort;
            default: ;
        endcase
    end

    assign mem_req_wdata = data_q;
    assign st_out_data   = data_q;
    assign busy          = (state_q != S_IDLE);
    assign wr_beat       = (state_q == S_MEM_WR) && mem_req_ready && !abort;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_ptr <= '0;
            buf_addr <= '0;
            remain   <= '0;
            data_q   <= '0;
            f_valid  <= 1'b0;
            f_last   <= 1'b0;
            f_xfer   <= 1'b0;
        end else begin
            if ((state_q == S_IDLE) && start)
                desc_ptr <= start_base & ALIGN_MASK;
            if ((state_q == S_WAIT_LO) && mem_rsp_valid) begin
                f_valid <= mem_rsp_rdata[FLAG_VALID];
                f_last  <= mem_rsp_rdata[FLAG_LAST];
                f_xfer  <= mem_rsp_rdata[FLAG_XFER];
                remain  <= mem_rsp_rdata[LEN_LSB +: LEN_W];
            end
            if ((state_q == S_WAIT_HI) && mem_rsp_valid)
                buf_addr <= mem_rsp_rdata[ADDR_W-1:0] & ALIGN_MASK;
            if ((state_q == S_RD_WAIT) && mem_rsp_valid)
                data_q <= mem_rsp_rdata;
            if ((state_q == S_PULL) && st_in_valid)
                data_q <= st_in_data;
            if (beat_done) begin
                buf_addr <= buf_addr + ADDR_W'(WORD_BYTES);
                remain   <= remain - LEN_W'(WORD_BYTES);
            end
            if ((state_q == S_ADVANCE) && !f_last)
                desc_ptr <= desc_ptr + ADDR_W'(DESC_BYTES);
        end
    end
endmodule

// File: rtl/dmac_row_count.sv
module dmac_row_count
    import dmac_pkg::*;
#(
    parameter int ROW_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             beat,
    input  logic [ROW_W-1:0] row_bytes,
    output logic             row_end
);
    logic [ROW_W-1:0] cnt_q;
    logic [ROW_W:0]   next_cnt;

    assign next_cnt = {1'b0, cnt_q} + (ROW_W+1)'(WORD_BYTES);
    assign row_end  = beat && (row_bytes != '0) && (next_cnt >= {1'b0, row_bytes});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clear)   cnt_q <= '0;
        else if (row_end) cnt_q <= '0;
        else if (beat)    cnt_q <= next_cnt[ROW_W-1:0];
    end
endmodule

// File: rtl/desc_chain_dma.sv
module desc_chain_dma
    import dmac_pkg::*;
#(
    parameter bit IS_RX  = 1'b1,
    parameter int ADDR_W = 32,
    parameter int ROW_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [WORD_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_rdata,
    input  logic              st_in_valid,
    output logic              st_in_ready,
    input  logic [WORD_W-1:0] st_in_data,
    output logic              st_out_valid,
    input  logic              st_out_ready,
    output logic [WORD_W-1:0] st_out_data,
    output logic              row_end,
    output logic              irq
);
    logic              start_w, abort_w, busy_w, done_w, err_w, beat_w;
    logic [ADDR_W-1:0] base_w;
    logic [ROW_W-1:0]  row_w;

    dmac_regs #(.IS_RX(IS_RX), .ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .busy(busy_w), .done_set(done_w), .err_set(err_w),
        .rdata(reg_rdata), .start_base(base_w), .row_bytes(row_w),
        .start(start_w), .abort(abort_w), .irq(irq)
    );

    dmac_seq #(.IS_RX(IS_RX), .ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start_w), .abort(abort_w),
        .start_base(base_w),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata),
        .st_in_valid(st_in_valid), .st_in_ready(st_in_ready), .st_in_data(st_in_data),
        .st_out_valid(st_out_valid), .st_out_ready(st_out_ready), .st_out_data(st_out_data),
        .busy(busy_w), .done_pulse(done_w), .err_pulse(err_w), .wr_beat(beat_w)
    );

    generate
        if (IS_RX) begin : g_row
            dmac_row_count #(.ROW_W(ROW_W)) u_row (
                .clk(clk), .rst_n(rst_n), .clear(start_w), .beat(beat_w),
                .row_bytes(row_w), .row_end(row_end)
            );
        end else begin : g_no_row
            assign row_end = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/dmac_checker.sv
module dmac_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              st_out_valid,
    input logic              st_out_ready,
    input logic [31:0]       st_out_data,
    input logic              start,
    input logic              abort,
    input logic              busy,
    input logic              done_pulse,
    input logic              err_pulse
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready && !abort) |=>
        (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write))); // R2

    AST_STREAM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_out_valid && !st_out_ready && !abort) |=>
        (st_out_valid && $stable(st_out_data))); // R11

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy); // R3

    AST_ERR_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> !done_pulse); // R4

    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> busy); // R7

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && !$past(done_pulse) && !$past(err_pulse))); // R9
endmodule

bind desc_chain_dma dmac_checker #(.ADDR_W(ADDR_W)) u_dmac_checker (
    .clk(clk), .rst_n(rst_n),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .st_out_valid(st_out_valid), .st_out_ready(st_out_ready), .st_out_data(st_out_data),
    .start(start_w), .abort(abort_w), .busy(busy_w),
    .done_pulse(done_w), .err_pulse(err_w)
);

// File: tb/dmac_mem_model.sv
module dmac_mem_model #(
    parameter bit STALL = 1'b0
) (
    input  logic        clk,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    input  logic        bd_we,
    input  logic [7:0]  bd_idx,
    input  logic [31:0] bd_data
);
    logic [31:0] mem [256];
    logic        tgl = 1'b0;
    logic        rv  = 1'b0;
    logic [31:0] rd  = '0;

    assign req_ready = STALL ? tgl : 1'b1;
    assign rsp_valid = rv;
    assign rsp_rdata = rd;

    always @(posedge clk) begin
        tgl <= ~tgl;
        rv  <= 1'b0;
        if (req_valid && req_ready) begin
            if (req_write) mem[req_addr[9:2]] <= req_wdata;
            else begin
                rv <= 1'b1;
                rd <= mem[req_addr[9:2]];
            end
        end
        if (bd_we) mem[bd_idx] <= bd_data;
    end
endmodule

// File: tb/desc_chain_dma_bench.sv
`timescale 1ns/1ps
module desc_chain_dma_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    // receive side
    logic        rx_wr_en = 0; logic [2:0] rx_addr = 0; logic [31:0] rx_wdata = 0;
    logic [31:0] rx_rdata;
    logic        rx_mv, rx_mr, rx_mw, rx_rv; logic [31:0] rx_ma, rx_md, rx_rd;
    logic        rx_src_en = 0; logic rx_in_ready; logic rx_row_end, rx_irq;
    logic        rx_ov; logic [31:0] rx_od;
    logic        rx_bd_we = 0; logic [7:0] rx_bd_idx = 0; logic [31:0] rx_bd_data = 0;
    int          rx_cnt = 0;
    int          row_cnt = 0;

    // transmit side
    logic        tx_wr_en = 0; logic [2:0] tx_addr = 0; logic [31:0] tx_wdata = 0;
    logic [31:0] tx_rdata;
    logic        tx_mv, tx_mr, tx_mw, tx_rv; logic [31:0] tx_ma, tx_md, tx_rd;
    logic        tx_in_ready, tx_row_end, tx_irq, tx_ov; logic [31:0] tx_od;
    logic        tx_bd_we = 0; logic [7:0] tx_bd_idx = 0; logic [31:0] tx_bd_data = 0;
    logic [2:0]  rdy_cnt = 0;
    logic        tx_out_ready;
    logic [31:0] cap [16];
    int          cap_n = 0;

    assign tx_out_ready = (rdy_cnt[1:0] != 2'b00);

    desc_chain_dma #(.IS_RX(1'b1)) u_desc_chain_dma (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(rx_wr_en), .reg_addr(rx_addr),
        .reg_wdata(rx_wdata), .reg_rdata(rx_rdata),
        .mem_req_valid(rx_mv), .mem_req_ready(rx_mr), .mem_req_write(rx_mw),
        .mem_req_addr(rx_ma), .mem_req_wdata(rx_md), .mem_rsp_valid(rx_rv),
        .mem_rsp_rdata(rx_rd), .st_in_valid(rx_src_en), .st_in_ready(rx_in_ready),
        .st_in_data(32'hA000_0000 + rx_cnt), .st_out_valid(rx_ov), .st_out_ready(1'b1),
        .st_out_data(rx_od), .row_end(rx_row_end), .irq(rx_irq)
    );
    dmac_mem_model #(.STALL(1'b0)) u_rx_mem (
        .clk(clk), .req_valid(rx_mv), .req_ready(rx_mr), .req_write(rx_mw),
        .req_addr(rx_ma), .req_wdata(rx_md), .rsp_valid(rx_rv), .rsp_rdata(rx_rd),
        .bd_we(rx_bd_we), .bd_idx(rx_bd_idx), .bd_data(rx_bd_data)
    );

    desc_chain_dma #(.IS_RX(1'b0)) u_desc_chain_dma_tx (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(tx_wr_en), .reg_addr(tx_addr),
        .reg_wdata(tx_wdata), .reg_rdata(tx_rdata),
        .mem_req_valid(tx_mv), .mem_req_ready(tx_mr), .mem_req_write(tx_mw),
        .mem_req_addr(tx_ma), .mem_req_wdata(tx_md), .mem_rsp_valid(tx_rv),
        .mem_rsp_rdata(tx_rd), .st_in_valid(1'b0), .st_in_ready(tx_in_ready),
        .st_in_data(32'h0), .st_out_valid(tx_ov), .st_out_ready(tx_out_ready),
        .st_out_data(tx_od), .row_end(tx_row_end), .irq(tx_irq)
    );
    dmac_mem_model #(.STALL(1'b1)) u_tx_mem (
        .clk(clk), .req_valid(tx_mv), .req_ready(tx_mr), .req_write(tx_mw),
        .req_addr(tx_ma), .req_wdata(tx_md), .rsp_valid(tx_rv), .rsp_rdata(tx_rd),
        .bd_we(tx_bd_we), .bd_idx(tx_bd_idx), .bd_data(tx_bd_data)
    );

    always @(posedge clk) begin
        if (rx_src_en && rx_in_ready) rx_cnt <= rx_cnt + 1;
        if (rx_row_end) row_cnt <= row_cnt + 1;
        rdy_cnt <= rdy_cnt + 1;
        if (tx_ov && tx_out_ready) begin
            cap[cap_n[3:0]] <= tx_od;
            cap_n <= cap_n + 1;
        end
    end

    typedef struct packed {
        logic [7:0]  flags;
        logic [15:0] len;
        logic [1:0]  status;
        logic [7:0]  words;
    } vec_t;

    localparam vec_t VEC [9] = '{
        '{8'h23, 16'd8,  2'b01, 8'd2},
        '{8'h23, 16'd4,  2'b01, 8'd1},
        '{8'h23, 16'd0,  2'b01, 8'd0},
        '{8'h22, 16'd8,  2'b10, 8'd0},
        '{8'h23, 16'd6,  2'b10, 8'd0},
        '{8'h03, 16'd8,  2'b01, 8'd0},
        '{8'h23, 16'd16, 2'b01, 8'd4},
        '{8'h21, 16'd2,  2'b10, 8'd0},
        '{8'h00, 16'd0,  2'b10, 8'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input bit tx, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        if (tx) begin tx_wr_en = 1; tx_addr = a; tx_wdata = d; end
        else    begin rx_wr_en = 1; rx_addr = a; rx_wdata = d; end
        @(negedge clk);
        tx_wr_en = 0; rx_wr_en = 0;
    endtask

    task automatic rd(input bit tx, input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        if (tx) tx_addr = a; else rx_addr = a;
        #1;
        d = tx ? tx_rdata : rx_rdata;
    endtask

    task automatic bd(input bit tx, input logic [7:0] idx, input logic [31:0] d);
        @(negedge clk);
        if (tx) begin tx_bd_we = 1; tx_bd_idx = idx; tx_bd_data = d; end
        else    begin rx_bd_we = 1; rx_bd_idx = idx; rx_bd_data = d; end
        @(negedge clk);
        tx_bd_we = 0; rx_bd_we = 0;
    endtask

    task automatic wait_idle(input bit tx);
        logic [31:0] s;
        for (int k = 0; k < 3000; k++) begin
            rd(tx, 3'd4, s);
            if (!s[2]) break;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail + 1);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int start_cnt;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd(0, 3'd4, v); check("R1 rx status", v, 0);
        rd(0, 3'd0, v); check("R1 rx ctrl", v, 0);
        rd(1, 3'd4, v); check("R1 tx status", v, 0);
        check("R1 irq", {30'b0, tx_irq, rx_irq}, 0);

        // R12 high register read back only
        wr(0, 3'd2, 32'hFFFF_FFF0);
        rd(0, 3'd2, v); check("R12 high readback", v, 32'hFFFF_FFF0);

        // vector table on the receive copy
        wr(0, 3'd5, 32'd3);
        rx_src_en = 1;
        for (int i = 0; i < 9; i++) begin
            bd(0, 8'd0, {VEC[i].len, 8'h00, VEC[i].flags});
            bd(0, 8'd1, 32'h0000_0100);
            for (int j = 0; j < 6; j++) bd(0, 8'(64 + j), 32'h5EED_0000 + j);
            start_cnt = rx_cnt;
            wr(0, 3'd1, 32'h0);
            wr(0, 3'd0, 32'd1);
            wait_idle(0);
            rd(0, 3'd4, v); check("R4 R5 R6 R7 status", v, {30'b0, VEC[i].status});
            check("R8 irq raised", {31'b0, rx_irq}, 1);
            for (int j = 0; j < int'(VEC[i].words); j++)
                check("R2 buffer word", u_rx_mem.mem[64 + j], 32'hA000_0000 + start_cnt + j);
            check("R6 untouched word", u_rx_mem.mem[64 + VEC[i].words],
                  32'h5EED_0000 + VEC[i].words);
            check("R2 words taken", rx_cnt - start_cnt, VEC[i].words);
            wr(0, 3'd4, 32'd3);
            rd(0, 3'd4, v); check("R8 cleared", v, 0);
        end
        wr(0, 3'd5, 32'd0);

        // R3 receive ignores list-low write as start
        wr(0, 3'd1, 32'h0);
        rd(0, 3'd0, v); check("R3 rx no start on list write", v, 0);

        // R7 R10 chain with a zero-length middle entry, row length 8
        wr(0, 3'd3, 32'd8);
        bd(0, 8'd0, 32'h0010_0021); bd(0, 8'd1, 32'h0000_0100);
        bd(0, 8'd2, 32'h0000_0021); bd(0, 8'd3, 32'h0000_0180);
        bd(0, 8'd4, 32'h0008_0023); bd(0, 8'd5, 32'h0000_0200);
        bd(0, 8'd96, 32'h5EED_0060);
        start_cnt = rx_cnt;
        row_cnt = row_cnt;
        v = row_cnt;
        wr(0, 3'd0, 32'd1);
        rd(0, 3'd0, v); check("R3 rx running", v, 1);
        v = row_cnt;
        wait_idle(0);
        check("R10 row pulses", row_cnt - int'(v), 3);
        rd(0, 3'd4, v); check("R7 chain done", v, 1);
        for (int j = 0; j < 4; j++)
            check("R7 first buffer", u_rx_mem.mem[64 + j], 32'hA000_0000 + start_cnt + j);
        check("R6 empty entry buffer", u_rx_mem.mem[96], 32'h5EED_0060);
        check("R7 third buffer 0", u_rx_mem.mem[128], 32'hA000_0000 + start_cnt + 4);
        check("R7 third buffer 1", u_rx_mem.mem[129], 32'hA000_0000 + start_cnt + 5);

        // R8 interrupt gating and write-one-to-clear
        check("R8 irq masked", {31'b0, rx_irq}, 0);
        wr(0, 3'd4, 32'd2);
        rd(0, 3'd4, v); check("R8 write of other bit keeps done", v, 1);
        wr(0, 3'd5, 32'd1);
        check("R8 irq enabled", {31'b0, rx_irq}, 1);
        wr(0, 3'd4, 32'd1);
        check("R8 irq after clear", {31'b0, rx_irq}, 0);
        wr(0, 3'd5, 32'd0);

        // R9 abort while waiting for stream data
        rx_src_en = 0;
        bd(0, 8'd0, 32'h0008_0023); bd(0, 8'd1, 32'h0000_0100);
        wr(0, 3'd1, 32'h0);
        wr(0, 3'd0, 32'd1);
        repeat (20) @(negedge clk);
        rd(0, 3'd0, v); check("R9 stalled busy", v, 1);
        wr(0, 3'd0, 32'd0);
        rd(0, 3'd4, v); check("R9 abort idle no status", v, 0);
        rx_src_en = 1;

        // R3 R11 transmit chain with stalls
        for (int j = 0; j < 3; j++) bd(1, 8'(64 + j), 32'hB000_0000 + j);
        for (int j = 0; j < 2; j++) bd(1, 8'(128 + j), 32'hC000_0000 + j);
        bd(1, 8'd8,  32'h000C_0021); bd(1, 8'd9,  32'h0000_0100);
        bd(1, 8'd10, 32'h0008_0023); bd(1, 8'd11, 32'h0000_0200);
        wr(1, 3'd0, 32'd1);
        rd(1, 3'd0, v); check("R3 tx no start on ctrl", v, 0);
        wr(1, 3'd1, 32'h0000_0020);
        rd(1, 3'd0, v); check("R3 tx start on list write", v, 1);
        wait_idle(1);
        rd(1, 3'd4, v); check("R7 tx done", v, 1);
        check("R11 tx word count", cap_n, 5);
        for (int j = 0; j < 3; j++) check("R11 tx word", cap[j], 32'hB000_0000 + j);
        for (int j = 0; j < 2; j++) check("R11 tx word", cap[3 + j], 32'hC000_0000 + j);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule